// File: doc/BRIEF.md
# Single-Slope Converter Sequencer

This block sequences a four-channel single-slope analog-to-digital conversion. One external ramp is shared by all four channels. A pulse on `sync_i` starts a conversion. The block keeps the ramp capacitor shorted for a short settling window. It then releases the short and starts a 12-bit timer from zero. Each channel's comparator output is synchronised and edge-detected. The first rising edge seen during the ramp stores the current timer value as that channel's result. A channel whose comparator never trips is given full scale.

Channels 0 to 2 are fixed inputs. Channel 3 is fed through an external 4-to-1 selector, and this block drives that selector's 2-bit code. The code is copied from `aux_sel_i` while the block is idle and is frozen for the whole conversion. Code `11` routes the internal voltage reference to channel 3 for calibration.

The control is a four-state machine with these states:
- `S_IDLE`: capacitor held in reset.
- `S_SETTLE`: capacitor still held in reset while the settling window is counted.
- `S_RAMP`: capacitor released and timer running.
- `S_FINISH`: a one-cycle done pulse.

The transitions are:
- `S_IDLE` to `S_SETTLE` on a sync pulse.
- `S_SETTLE` to `S_RAMP` after `SETTLE_CYC` clocks.
- `S_RAMP` to `S_FINISH` when every channel has captured or the timer reads 4095.
- `S_FINISH` to `S_IDLE` unconditionally.

Top module: `ramp_adc_sequencer`

## Requirements
- R1: After reset, `cap_rst_o` is 1, `done_o` is 0, `result_o` is all zeros and `aux_sel_o` is 00, whatever `aux_sel_i` holds during reset.
- R2: `cap_rst_o` is 1 in every idle cycle. After an accepted sync pulse it stays 1 for exactly `SETTLE_CYC` (default 4) further clocks. It is then 0 for every ramp cycle, and it is 1 again in the cycle where `done_o` is 1.
- R3: The timer reads 0 in the first ramp cycle and rises by exactly one per clock. A channel's result equals the number of ramp cycles that elapse before its comparator is first sampled high, plus 2 for the synchroniser.
- R4: All four channels are timed against the same timer in the same conversion, each independently. Equal crossing times give equal codes. Channel i's result sits at `result_o[12*i+11:12*i]`.
- R5: Only the first comparator rising edge in a conversion is stored. A later fall and rise on that channel leaves its result unchanged.
- R6: A channel whose comparator does not trip before the timer reaches 4095 gets result 4095. The timer never wraps, and the ramp ends after timer value 4095.
- R7: A comparator that is already high before the ramp starts gives no edge during the ramp, so that channel's result is 4095.
- R8: `done_o` is high for exactly one clock. That clock is two cycles after the cycle in which the last channel's capture is stored. If the timer reaches 4095 first, it is the cycle after the timer shows 4095. With default parameters, `done_o` therefore appears in ramp-relative cycle min(last crossing + 4, 4096).
- R9: Results change only through a capture or saturation during the ramp. Comparator activity between conversions leaves every result unchanged.
- R10: A sync pulse during a settle, ramp or finish cycle is ignored. The ramp continues and results and done timing are unaffected.
- R11: `aux_sel_o` follows `aux_sel_i` one clock later while idle. It holds the value present at the accepted sync until the conversion ends. Code 00 selects aux input 0, 01 aux input 1, 10 aux input 2, and 11 the calibration reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and control clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Conversion start pulse |
| cmp_i | input | 4 | Comparator outputs, one per channel, asynchronous |
| aux_sel_i | input | 2 | Requested source code for channel 3 |
| cap_rst_o | output | 1 | Ramp capacitor short, 1 = discharge |
| aux_sel_o | output | 2 | Selector code driven to the channel-3 multiplexer |
| result_o | output | 48 | Four 12-bit results, channel i at bits 12*i+11:12*i |
| done_o | output | 1 | One-cycle conversion complete pulse |

## Verification
Conversions are run with the following comparator patterns:
- Four distinct crossing times. A swapped or shared capture register shows up here.
- All four crossing at once. This shows that each channel keeps its own captured flag.
- A fall and re-rise after capture. This tests the first-edge rule.
- Channels that never trip or are high before the ramp starts. These push the run to saturation and tell an early or late timer stop from correct full-scale filling.
- A crossing two counts below full scale. This separates an off-by-one in the saturation compare from a correct end of ramp.

Each conversion also checks the settle length, the exact done cycle, a sync pulse injected mid-ramp and a selector change during the ramp. Together these separate a restarted conversion from an ignored sync, and a frozen select code from one that tracks its input.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETTLE = 2'd1,
        S_RAMP   = 2'd2,
        S_FINISH = 2'd3
    } conv_state_e;

    typedef enum logic [1:0] {
        AUX_IN0  = 2'b00,
        AUX_IN1  = 2'b01,
        AUX_IN2  = 2'b10,
        AUX_VREF = 2'b11
    } aux_src_e;

endpackage

// File: rtl/ramp_adc_sync_edge.sv
module ramp_adc_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic async_i,
    output logic rise_o
);
    // Stages 0..SYNC_STAGES-1 synchronise; the extra top stage keeps the
    // previous synchronised level for edge detection.
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], async_i};
        end
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/ramp_adc_timer.sv
module ramp_adc_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             clr_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign full_o = (cnt_q == CNT_MAX);

    // R3
    step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && !clr_i && !full_o) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R6
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (full_o && !clr_i) |=> full_o);

endmodule

// File: rtl/ramp_adc_chan.sv
module ramp_adc_chan #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             arm_i,
    input  logic             open_i,
    input  logic             rise_i,
    input  logic             fill_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] res_o,
    output logic             got_o
);
    logic [CNT_W-1:0] res_q;
    logic             got_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            res_q <= '0;
            got_q <= 1'b0;
        end else if (arm_i) begin
            got_q <= 1'b0;
        end else if (open_i && !got_q && rise_i) begin
            res_q <= cnt_i;
            got_q <= 1'b1;
        end else if (fill_i && !got_q) begin
            res_q <= '1;
            got_q <= 1'b1;
        end
    end

    assign res_o = res_q;
    assign got_o = got_q;

    // R5
    first_edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (got_o && !arm_i) |=> $stable(res_o));

    // R9
    frozen_outside_ramp_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!open_i && !fill_i) |=> $stable(res_o));

endmodule

// File: rtl/ramp_adc_sequencer.sv
module ramp_adc_sequencer
    import ramp_adc_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int CNT_W       = 12,
    parameter int SETTLE_CYC  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    input  logic                 sync_i,
    input  logic [NCH-1:0]       cmp_i,
    input  logic [1:0]           aux_sel_i,
    output logic                 cap_rst_o,
    output logic [1:0]           aux_sel_o,
    output logic [NCH*CNT_W-1:0] result_o,
    output logic                 done_o
);
    localparam int               SET_W       = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SET_W-1:0] SETTLE_LAST = SET_W'(SETTLE_CYC - 1);

    conv_state_e      state_q, state_d;
    logic [SET_W-1:0] settle_q;
    aux_src_e         aux_q;

    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_full;
    logic             accept;
    logic             in_ramp;
    logic [NCH-1:0]   rise;
    logic [NCH-1:0]   got;
    logic             all_got;
    logic [CNT_W-1:0] res_w [NCH];

    assign accept  = (state_q == S_IDLE) && sync_i;
    assign in_ramp = (state_q == S_RAMP);
    assign all_got = &got;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (sync_i)                    state_d = S_SETTLE;
            S_SETTLE: if (settle_q == SETTLE_LAST)   state_d = S_RAMP;
            S_RAMP:   if (tmr_full || all_got)       state_d = S_FINISH;
            S_FINISH:                                state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Settling window counter
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            settle_q <= '0;
        end else if (state_q == S_SETTLE) begin
            settle_q <= settle_q + 1'b1;
        end else begin
            settle_q <= '0;
        end
    end

    // Selector code register, open only while idle
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            aux_q <= AUX_IN0;
        end else if (state_q == S_IDLE) begin
            aux_q <= aux_src_e'(aux_sel_i);
        end
    end

    // Outputs decoded from state
    always_comb begin
        cap_rst_o = 1'b1;
        done_o    = 1'b0;
        unique case (state_q)
            S_IDLE:   cap_rst_o = 1'b1;
            S_SETTLE: cap_rst_o = 1'b1;
            S_RAMP:   cap_rst_o = 1'b0;
            S_FINISH: done_o    = 1'b1;
        endcase
    end

    assign aux_sel_o = aux_q;

    ramp_adc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .clr_i   (state_q == S_SETTLE),
        .run_i   (in_ramp),
        .cnt_o   (tmr_cnt),
        .full_o  (tmr_full)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        ramp_adc_sync_edge #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_edge (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .async_i (cmp_i[i]),
            .rise_o  (rise[i])
        );

        ramp_adc_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .arm_i   (accept),
            .open_i  (in_ramp),
            .rise_i  (rise[i]),
            .fill_i  (in_ramp && tmr_full),
            .cnt_i   (tmr_cnt),
            .res_o   (res_w[i]),
            .got_o   (got[i])
        );

        assign result_o[i*CNT_W +: CNT_W] = res_w[i];
    end

    // R2
    idle_holds_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == S_IDLE && !sync_i) |=> (cap_rst_o && !done_o));

    // R8
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_o |=> !done_o);

    // R8
    done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(done_o) |-> $past(all_got || tmr_full));

    // R10
    busy_sync_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_ramp && sync_i && !tmr_full && !all_got) |=> (state_q == S_RAMP));

    // R11
    aux_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q != S_IDLE) |=> $stable(aux_sel_o));

endmodule

// File: tb/ramp_adc_sequencer_bench.sv
`timescale 1ns/1ps
module ramp_adc_sequencer_bench;
    localparam int NCH        = 4;
    localparam int CNT_W      = 12;
    localparam int SETTLE_CYC = 4;
    localparam int MAXV       = 4095;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sync = 1'b0;
    logic [NCH-1:0]       cmp = '0;
    logic [1:0]           aux_in = 2'b10;
    logic                 cap_rst;
    logic [1:0]           aux_out;
    logic [NCH*CNT_W-1:0] result;
    logic                 done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    typedef struct {
        int    ch;
        int    val;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    ramp_adc_sequencer u_ramp_adc_sequencer (
        .clk_i     (clk),
        .rst_n_i   (rst_n),
        .sync_i    (sync),
        .cmp_i     (cmp),
        .aux_sel_i (aux_in),
        .cap_rst_o (cap_rst),
        .aux_sel_o (aux_out),
        .result_o  (result),
        .done_o    (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int res_of(input int i);
        return int'(result[i*CNT_W +: CNT_W]);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Monitor: pop one expected code per channel at each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            for (int i = 0; i < NCH; i++) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4", "no expectation queued", res_of(i), -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(res_of(e.ch) == e.val, e.req,
                          $sformatf("ch%0d result", e.ch), res_of(e.ch), e.val);
                end
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                check(1'b0, "R8", "watchdog expired", cyc, 150000);
                summary();
                $finish;
            end
        end
    end

    // Driver: d >= 0 crossing in ramp cycle d, -1 never, -2 high before start
    task automatic conv(input int d[NCH], input logic [1:0] code,
                        input bit redo, input bit mid_sync);
        int    exp_v[NCH];
        int    dmax   = -1;
        bit    never  = 1'b0;
        int    done_j;
        int    j;
        int    n_set;
        string rq;
        for (int i = 0; i < NCH; i++) begin
            if (d[i] < 0) begin
                exp_v[i] = MAXV;
                never    = 1'b1;
                rq       = (d[i] == -2) ? "R7" : "R6";
            end else begin
                exp_v[i] = (d[i] + 2 > MAXV) ? MAXV : d[i] + 2;
                if (d[i] > dmax) dmax = d[i];
                rq = "R3";
            end
            sb_q.push_back('{ch: i, val: exp_v[i], req: rq});
        end
        done_j = never ? 4096 : ((dmax + 4 < 4096) ? dmax + 4 : 4096);

        aux_in = code;
        for (int i = 0; i < NCH; i++) if (d[i] == -2) cmp[i] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(aux_out == code, "R11", "select follows input while idle", aux_out, code);

        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        n_set = 0;
        while (cap_rst) begin
            n_set++;
            @(negedge clk);
        end
        check(n_set == SETTLE_CYC, "R2", "settle cycles with capacitor held", n_set, SETTLE_CYC);

        j = 0;
        while (!done) begin
            for (int i = 0; i < NCH; i++) begin
                if (d[i] == j) cmp[i] = 1'b1;
                if (redo && d[i] >= 0 && j == d[i] + 3) cmp[i] = 1'b0;
                if (redo && d[i] >= 0 && j == d[i] + 6) cmp[i] = 1'b1;
            end
            sync = (mid_sync && j == 5);
            if (j == 2) aux_in = code ^ 2'b11;
            if (j == 8) check(aux_out == code, "R11", "select frozen in ramp", aux_out, code);
            if (mid_sync && j == 7) check(cap_rst == 1'b0, "R10", "ramp kept after busy sync", cap_rst, 0);
            @(negedge clk);
            j++;
        end
        check(j == done_j, "R8", "done cycle", j, done_j);
        check(cap_rst == 1'b1, "R2", "capacitor reset with done", cap_rst, 1);
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", done, 0);

        cmp = '1;
        repeat (4) @(negedge clk);
        cmp = '0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < NCH; i++)
            check(res_of(i) == exp_v[i], "R9", $sformatf("ch%0d held while idle", i), res_of(i), exp_v[i]);
        check(aux_out == (code ^ 2'b11), "R11", "select tracks after end", aux_out, code ^ 2'b11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cap_rst == 1'b1, "R1", "reset cap_rst", cap_rst, 1);
        check(done == 1'b0, "R1", "reset done", done, 0);
        check(result == '0, "R1", "reset results", (result == '0) ? 0 : 1, 0);
        check(aux_out == 2'b00, "R1", "reset select", aux_out, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        conv('{10, 25, 40, 55}, 2'b00, 1'b0, 1'b0);   // R4 distinct crossings
        conv('{30, 30, 30, 30}, 2'b01, 1'b0, 1'b0);   // R4 simultaneous
        conv('{0, 7, 100, 3},   2'b10, 1'b1, 1'b0);   // R5 re-rise ignored
        conv('{-1, 50, 20, -1}, 2'b11, 1'b0, 1'b0);   // R6 saturation
        conv('{-2, 15, 15, 60}, 2'b11, 1'b0, 1'b1);   // R7 early high, R10 busy sync
        conv('{4092, 5, 6, 7},  2'b01, 1'b0, 1'b0);   // R6 boundary near full scale

        check(sb_q.size() == 0, "R8", "unconsumed expectations", sb_q.size(), 0);
        summary();
        $finish;
    end

endmodule